// File: doc/BRIEF.md
# SD Host Data Port with DMA Handshake

This block handles the data half of a simple MMC/SD host controller. Software, or a DMA engine, reaches it through a small word-wide register port with three locations: a control word, a length word and a data window. Writing the control word with its start bit set does three things. It copies the length into an internal count of bytes still to move and clears the transfer flags. The start bit does not stay set.

Each later access to the data window moves up to four bytes between the 32-bit bus and a byte-wide card interface. Bytes travel lowest lane first, and each byte lowers the remaining count by one. A read assembles card bytes into a little-endian word. A write splits the written word into bytes and sends them to the card. The bus access stalls while the bytes move, one per clock.

Two flags report progress: one for any word moved, and one for the count reaching zero. A request/acknowledge pair paces an external DMA engine. The request rises when a command is issued with bytes pending. It drops on a rising acknowledge and comes back on a falling acknowledge while bytes remain.

Top module: `sd_data_port`

## Requirements
- R1: After reset the control and length words read back zero, the DMA request is low and both transfer flags are low.
- R2: The control word keeps bits 10:0 of a write and reads them back on bits 10:0, with bit 6 (start) always reading zero. Bits 31:11 read zero. Bit 4 selects direction (1 = towards the card, 0 = from the card) and bit 5 enables DMA pacing. The control word is address 0, the length word address 1 and the data window address 2. The length word keeps the low LEN_W bits of a write.
- R3: A control write with bit 6 set loads the remaining count from the length word and clears both transfer flags. A control write with bit 6 clear leaves the count unchanged.
- R4: A data read with direction 0, a nonzero count and card_rd_ready high takes min(count,4) bytes from the card. The byte taken i-th goes to bus_rdata bits 8i+7:8i, unused lanes read zero, and each byte lowers the count by one.
- R5: A data write with direction 1 and a nonzero count sends min(count,4) bytes of bus_wdata to the card, bits 7:0 first, lowering the count by one per byte.
- R6: Every data access that moves bytes sets the progress flag. When it brings the count to zero it also sets the end flag.
- R7: A data read that moves nothing (count zero, card not ready, or direction 1) returns zero and strobes no card byte. A data write with direction 0 sends nothing and leaves the count unchanged.
- R8: With DMA enabled, a one-cycle command-issue pulse raises the request when the count is nonzero. A rising acknowledge lowers it. A falling acknowledge raises it again only if the count is nonzero.
- R9: With DMA disabled, acknowledge edges and command-issue pulses leave the request level unchanged.
- R10: bus_ready is a one-cycle pulse. It appears n+1 clocks after the access is first sampled, where n is the number of bytes the access moves (0 for register accesses and accesses that move nothing).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request, held until bus_ready |
| bus_wr | input | 1 | 1 = write access |
| bus_addr | input | 2 | Word address: 0 control, 1 length, 2 data window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| bus_ready | output | 1 | Access completion pulse |
| card_rd_ready | input | 1 | Card has read data available |
| card_rd_byte | input | 8 | Byte offered by the card |
| card_rd_strb | output | 1 | Consume card_rd_byte this clock |
| card_wr_byte | output | 8 | Byte sent to the card |
| card_wr_strb | output | 1 | card_wr_byte is valid this clock |
| cmd_issue | input | 1 | One-cycle pulse when a command is sent |
| dma_ack | input | 1 | Acknowledge from the DMA engine |
| dma_req | output | 1 | Request level to the DMA engine |
| stat_progress | output | 1 | A data word was moved |
| stat_end | output | 1 | Remaining count reached zero |

## Verification
The bench builds the block with LEN_W = 8 and the default four bytes per word. With that width, lengths of five and six force a short final word, so partial packing, zero-filled upper lanes and the shortened stall are all reached. The same short lengths cover the end flag setting on the last byte, the falling acknowledge meeting a count that is nonzero and one that is zero, and accesses that find the count already empty.

// File: rtl/sd_dp_pkg.sv
package sd_dp_pkg;
    localparam int unsigned CTRL_BITS = 11;
    localparam int unsigned CB_DIR    = 4;
    localparam int unsigned CB_DMA    = 5;
    localparam int unsigned CB_START  = 6;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_LEN  = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    typedef enum logic [1:0] {
        XS_IDLE = 2'd0,
        XS_MOVE = 2'd1,
        XS_ACK  = 2'd2
    } xfer_st_e;
endpackage

// File: rtl/sd_dp_regs.sv
module sd_dp_regs
    import sd_dp_pkg::*;
#(
    parameter int unsigned LEN_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_ctrl_i,
    input  logic                 wr_len_i,
    input  logic [CTRL_BITS-1:0] ctrl_wdata_i,
    input  logic [LEN_W-1:0]     len_wdata_i,
    output logic [CTRL_BITS-1:0] ctrl_o,
    output logic [LEN_W-1:0]     len_o,
    output logic                 load_o
);
    typedef struct packed {
        logic [CTRL_BITS-1:0] ctrl;
        logic [LEN_W-1:0]     len;
    } regs_t;

    regs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_ctrl_i) begin
            s_d.ctrl           = ctrl_wdata_i;
            s_d.ctrl[CB_START] = 1'b0;
        end
        if (wr_len_i) begin
            s_d.len = len_wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctrl_o = s_q.ctrl;
    assign len_o  = s_q.len;
    assign load_o = wr_ctrl_i & ctrl_wdata_i[CB_START];

    assert_start_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl_i |=> (ctrl_o[CB_START] == 1'b0));
endmodule

// File: rtl/sd_dp_xfer.sv
module sd_dp_xfer
    import sd_dp_pkg::*;
#(
    parameter int unsigned LEN_W = 16,
    parameter int unsigned BPW   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [1:0]           bus_addr,
    input  logic [8*BPW-1:0]     bus_wdata,
    output logic [8*BPW-1:0]     bus_rdata,
    output logic                 bus_ready,
    input  logic [CTRL_BITS-1:0] ctrl_i,
    input  logic [LEN_W-1:0]     len_i,
    input  logic                 load_i,
    output logic                 wr_ctrl_o,
    output logic                 wr_len_o,
    input  logic                 card_rd_ready,
    input  logic [7:0]           card_rd_byte,
    output logic                 card_rd_strb,
    output logic [7:0]           card_wr_byte,
    output logic                 card_wr_strb,
    output logic                 cnt_nz_o,
    output logic                 stat_progress,
    output logic                 stat_end
);
    localparam int unsigned WORD_W = 8 * BPW;
    localparam int unsigned IDX_W  = (BPW > 1) ? $clog2(BPW) : 1;

    typedef struct packed {
        xfer_st_e          st;
        logic [LEN_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [IDX_W-1:0]  last;
        logic [WORD_W-1:0] word;
        logic [WORD_W-1:0] rdata;
        logic              prog;
        logic              dend;
    } xfer_t;

    xfer_t s_d, s_q;

    logic dir_w, cnt_nz, is_data, do_wr, do_rd;
    logic [IDX_W-1:0] first_last;

    assign dir_w   = ctrl_i[CB_DIR];
    assign cnt_nz  = (s_q.cnt != '0);
    assign is_data = (bus_addr == ADDR_DATA);
    assign do_wr   = bus_wr & dir_w & cnt_nz;
    assign do_rd   = ~bus_wr & ~dir_w & cnt_nz & card_rd_ready;

    always_comb begin
        if (s_q.cnt >= LEN_W'(BPW)) first_last = IDX_W'(BPW - 1);
        else                        first_last = IDX_W'(s_q.cnt - LEN_W'(1));
    end

    assign wr_ctrl_o = (s_q.st == XS_IDLE) & bus_sel & bus_wr & (bus_addr == ADDR_CTRL);
    assign wr_len_o  = (s_q.st == XS_IDLE) & bus_sel & bus_wr & (bus_addr == ADDR_LEN);

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            XS_IDLE: begin
                if (bus_sel) begin
                    s_d.st    = XS_ACK;
                    s_d.rdata = '0;
                    if (is_data && (do_wr || do_rd)) begin
                        s_d.st   = XS_MOVE;
                        s_d.idx  = '0;
                        s_d.last = first_last;
                        s_d.word = do_wr ? bus_wdata : '0;
                    end else if (!bus_wr) begin
                        if (bus_addr == ADDR_CTRL)
                            s_d.rdata = WORD_W'(ctrl_i);
                        else if (bus_addr == ADDR_LEN)
                            s_d.rdata = WORD_W'(len_i);
                    end
                end
                if (load_i) begin
                    s_d.cnt  = len_i;
                    s_d.prog = 1'b0;
                    s_d.dend = 1'b0;
                end
            end
            XS_MOVE: begin
                s_d.cnt = s_q.cnt - LEN_W'(1);
                if (!dir_w) s_d.word[s_q.idx*8 +: 8] = card_rd_byte;
                s_d.idx = s_q.idx + IDX_W'(1);
                if (s_q.idx == s_q.last) begin
                    s_d.st    = XS_ACK;
                    s_d.prog  = 1'b1;
                    s_d.rdata = dir_w ? '0 : s_d.word;
                    if (s_q.cnt == LEN_W'(1)) s_d.dend = 1'b1;
                end
            end
            default: begin
                s_d.st = XS_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: XS_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign bus_ready     = (s_q.st == XS_ACK);
    assign bus_rdata     = s_q.rdata;
    assign card_rd_strb  = (s_q.st == XS_MOVE) & ~dir_w;
    assign card_wr_strb  = (s_q.st == XS_MOVE) & dir_w;
    assign card_wr_byte  = s_q.word[s_q.idx*8 +: 8];
    assign cnt_nz_o      = cnt_nz;
    assign stat_progress = s_q.prog;
    assign stat_end      = s_q.dend;

    assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> !bus_ready);
    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == XS_MOVE) |=> (s_q.cnt == $past(s_q.cnt) - LEN_W'(1)));
    assert_end_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_end) |-> (s_q.cnt == '0));
    assert_no_strobe_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (card_rd_strb || card_wr_strb) |-> cnt_nz);
endmodule

// File: rtl/sd_dp_dma.sv
module sd_dp_dma (
    input  logic clk,
    input  logic rst_n,
    input  logic dma_en_i,
    input  logic cnt_nz_i,
    input  logic cmd_issue_i,
    input  logic ack_i,
    output logic req_o
);
    typedef struct packed {
        logic ack;
        logic req;
    } hs_t;

    hs_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.ack = ack_i;
        if (dma_en_i) begin
            if (ack_i && !s_q.ack)
                s_d.req = 1'b0;
            else if (!ack_i && s_q.ack && cnt_nz_i)
                s_d.req = 1'b1;
            else if (cmd_issue_i && cnt_nz_i)
                s_d.req = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req_o = s_q.req;

    assert_req_rise_needs_dma_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) |-> $past(dma_en_i));
    assert_ack_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en_i |=> (req_o == $past(req_o)));
endmodule

// File: rtl/sd_data_port.sv
module sd_data_port
    import sd_dp_pkg::*;
#(
    parameter int unsigned LEN_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        bus_ready,
    input  logic        card_rd_ready,
    input  logic [7:0]  card_rd_byte,
    output logic        card_rd_strb,
    output logic [7:0]  card_wr_byte,
    output logic        card_wr_strb,
    input  logic        cmd_issue,
    input  logic        dma_ack,
    output logic        dma_req,
    output logic        stat_progress,
    output logic        stat_end
);
    localparam int unsigned BPW = 4;

    logic [CTRL_BITS-1:0] ctrl;
    logic [LEN_W-1:0]     len;
    logic                 load, wr_ctrl, wr_len, cnt_nz;

    sd_dp_regs #(.LEN_W(LEN_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_ctrl_i    (wr_ctrl),
        .wr_len_i     (wr_len),
        .ctrl_wdata_i (bus_wdata[CTRL_BITS-1:0]),
        .len_wdata_i  (bus_wdata[LEN_W-1:0]),
        .ctrl_o       (ctrl),
        .len_o        (len),
        .load_o       (load)
    );

    sd_dp_xfer #(.LEN_W(LEN_W), .BPW(BPW)) u_xfer (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_sel       (bus_sel),
        .bus_wr        (bus_wr),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .bus_ready     (bus_ready),
        .ctrl_i        (ctrl),
        .len_i         (len),
        .load_i        (load),
        .wr_ctrl_o     (wr_ctrl),
        .wr_len_o      (wr_len),
        .card_rd_ready (card_rd_ready),
        .card_rd_byte  (card_rd_byte),
        .card_rd_strb  (card_rd_strb),
        .card_wr_byte  (card_wr_byte),
        .card_wr_strb  (card_wr_strb),
        .cnt_nz_o      (cnt_nz),
        .stat_progress (stat_progress),
        .stat_end      (stat_end)
    );

    sd_dp_dma u_dma (
        .clk         (clk),
        .rst_n       (rst_n),
        .dma_en_i    (ctrl[CB_DMA]),
        .cnt_nz_i    (cnt_nz),
        .cmd_issue_i (cmd_issue),
        .ack_i       (dma_ack),
        .req_o       (dma_req)
    );
endmodule

// File: tb/sim_sd_data_port.sv
module sim_sd_data_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic        card_rd_ready = 1'b1;
    logic [7:0]  card_rd_byte;
    logic        card_rd_strb, card_wr_strb;
    logic [7:0]  card_wr_byte;
    logic        cmd_issue = 1'b0, dma_ack = 1'b0;
    logic        dma_req, stat_progress, stat_end;

    int checks = 0, fails = 0;
    logic [7:0]  rd_ptr = 8'd0;
    int          wr_n = 0;
    logic [31:0] wr_word = '0;

    always #10 clk = ~clk;

    sd_data_port #(.LEN_W(8)) u0 (.*);

    assign card_rd_byte = 8'h10 + rd_ptr;
    always @(posedge clk) begin
        if (card_rd_strb) rd_ptr <= rd_ptr + 8'd1;
        if (card_wr_strb) begin
            wr_word <= {card_wr_byte, wr_word[31:8]};
            wr_n    <= wr_n + 1;
        end
    end

    // {wr, addr, wdata, expected rdata, expected latency}
    localparam int NV = 13;
    localparam logic [70:0] VEC [NV] = '{
        {1'b1, 2'd1, 32'h0000_0006, 32'h0, 4'd1},          // R2 length
        {1'b0, 2'd1, 32'h0, 32'h0000_0006, 4'd1},          // R2 length readback
        {1'b1, 2'd0, 32'h0000_0342, 32'h0, 4'd1},          // R3 start, read dir
        {1'b0, 2'd0, 32'h0, 32'h0000_0302, 4'd1},          // R2 start reads zero
        {1'b0, 2'd2, 32'h0, 32'h1312_1110, 4'd5},          // R4 full word
        {1'b0, 2'd2, 32'h0, 32'h0000_1514, 4'd3},          // R4 short word
        {1'b0, 2'd2, 32'h0, 32'h0, 4'd1},                  // R7 count zero
        {1'b1, 2'd1, 32'h0000_0005, 32'h0, 4'd1},
        {1'b1, 2'd0, 32'h0000_0050, 32'h0, 4'd1},          // R3 start, write dir
        {1'b0, 2'd2, 32'h0, 32'h0, 4'd1},                  // R7 wrong direction
        {1'b1, 2'd2, 32'hA1B2_C3D4, 32'h0, 4'd5},          // R5 full word
        {1'b1, 2'd2, 32'h0000_0099, 32'h0, 4'd2},          // R5 one byte
        {1'b0, 2'd0, 32'h0, 32'h0000_0010, 4'd1}           // R2 readback
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_op(input logic wr, input logic [1:0] addr, input logic [31:0] wd,
                          output logic [31:0] rd, output int lat);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = addr; bus_wdata = wd;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!bus_ready && lat < 50);
        rd = bus_rdata;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic pulse_issue();
        @(negedge clk); cmd_issue = 1'b1;
        @(negedge clk); cmd_issue = 1'b0;
    endtask

    task automatic set_ack(input logic v);
        @(negedge clk); dma_ack = v;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        int lat;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 req", {31'b0, dma_req}, 32'h0);
        check("R1 flags", {30'b0, stat_progress, stat_end}, 32'h0);
        bus_op(1'b0, 2'd0, 32'h0, rd, lat); check("R1 ctrl", rd, 32'h0);
        bus_op(1'b0, 2'd1, 32'h0, rd, lat); check("R1 len", rd, 32'h0);

        for (int i = 0; i < NV; i++) begin
            bus_op(VEC[i][70], VEC[i][69:68], VEC[i][67:36], rd, lat);
            check($sformatf("R4/R5/R2 vec%0d data", i), rd, VEC[i][35:4]);
            check($sformatf("R10 vec%0d latency", i), 32'(lat), 32'(VEC[i][3:0]));
        end

        check("R4 card bytes read", 32'(rd_ptr), 32'd6);
        check("R5 card bytes written", 32'(wr_n), 32'd5);
        check("R5 byte order", wr_word, 32'h99A1_B2C3);
        check("R6 end flag", {30'b0, stat_progress, stat_end}, 32'h3);

        // R3 start clears flags
        bus_op(1'b1, 2'd0, 32'h0000_0040, rd, lat);
        check("R3 flags cleared", {30'b0, stat_progress, stat_end}, 32'h0);
        // R7 card not ready
        card_rd_ready = 1'b0;
        bus_op(1'b0, 2'd2, 32'h0, rd, lat);
        check("R7 not ready data", rd, 32'h0);
        check("R7 no strobe", 32'(rd_ptr), 32'd6);
        check("R6 no progress", {30'b0, stat_progress, stat_end}, 32'h0);
        card_rd_ready = 1'b1;
        bus_op(1'b0, 2'd2, 32'h0, rd, lat);
        check("R4 after ready", rd, 32'h1918_1716);
        check("R6 progress only", {30'b0, stat_progress, stat_end}, 32'h2);
        // R7 write in read direction: count unchanged (1 left)
        bus_op(1'b1, 2'd2, 32'hFFFF_FFFF, rd, lat);
        check("R7 write ignored", 32'(wr_n), 32'd5);
        bus_op(1'b0, 2'd2, 32'h0, rd, lat);
        check("R7 count kept", rd, 32'h0000_001A);
        check("R3 non-start keeps", 32'(lat), 32'd2);

        // R8 DMA handshake
        bus_op(1'b1, 2'd1, 32'd3, rd, lat);
        bus_op(1'b1, 2'd0, 32'h0000_0060, rd, lat);
        check("R8 idle req", {31'b0, dma_req}, 32'h0);
        pulse_issue();
        check("R8 issue raises", {31'b0, dma_req}, 32'h1);
        set_ack(1'b1);
        check("R8 ack rise drops", {31'b0, dma_req}, 32'h0);
        set_ack(1'b0);
        check("R8 ack fall re-arms", {31'b0, dma_req}, 32'h1);
        bus_op(1'b0, 2'd2, 32'h0, rd, lat);
        check("R8 dma word", rd, 32'h001D_1C1B);
        set_ack(1'b1);
        set_ack(1'b0);
        check("R8 no re-arm at zero", {31'b0, dma_req}, 32'h0);
        pulse_issue();
        check("R8 issue at zero", {31'b0, dma_req}, 32'h0);

        // R9 DMA disabled
        bus_op(1'b1, 2'd1, 32'd2, rd, lat);
        bus_op(1'b1, 2'd0, 32'h0000_0060, rd, lat);
        pulse_issue();
        check("R9 setup req", {31'b0, dma_req}, 32'h1);
        bus_op(1'b1, 2'd0, 32'h0000_0000, rd, lat);
        set_ack(1'b1);
        check("R9 ack rise ignored", {31'b0, dma_req}, 32'h1);
        set_ack(1'b0);
        check("R9 ack fall ignored", {31'b0, dma_req}, 32'h1);

        finish_run();
    end
endmodule